// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a small data cache placed between a processor's load/store port and a word-wide main-memory port. Every line holds exactly one 32-bit word together with a tag and a valid flag. A load is looked up in the same cycle it is presented. When the indexed line is valid and its tag matches, the word is returned at once with no stall. On a miss the processor is held while the word is read from memory and written into the line, and the word is then handed to the processor.

Stores never ask whether they hit. The indexed line is simply overwritten with the new tag and data and marked valid, and the word is also sent to memory. The processor is held until memory acknowledges the write, so the memory always holds every stored word. The memory side is a request/acknowledge handshake that may take any number of cycles.

The processor keeps its request, write flag, address and store data steady for as long as the stall output is high. The access completes in the first cycle in which the stall output is low.

Top module: `dmc_cache`

## Requirements
- R1: A synchronous active-low reset clears every valid flag, so the first load to any address after reset is a miss. This holds even for an address that was cached before the reset.
- R2: A load hits when the indexed line is valid and its stored tag equals the address tag. On a hit, `cpu_stall` stays low, `cpu_rdata` carries the line's word in the same cycle, and no memory request is made.
- R3: On a load miss, `cpu_stall` is high in the request cycle. In the next cycle `mem_req` rises with `mem_we` low and `mem_addr` equal to the load address with bits 1:0 forced to zero.
- R4: In the cycle after the cycle in which `mem_ack` is high for a read, `cpu_stall` is low and `cpu_rdata` equals the `mem_rdata` value that was acknowledged. The line now holds that word, so a repeat load hits.
- R5: The line index is address bits [IDX_W+1:2] (IDX_W=8 by default, giving 256 lines), and the tag is the bits above the index. Two addresses that differ only by a multiple of 2^(IDX_W+2) share one line, and loading one of them evicts the other.
- R6: Address bits 1:0 are a byte offset and play no part in the lookup. A load that differs from a cached address only in those bits hits and returns the same word.
- R7: A store holds `cpu_stall` high and overwrites the indexed line's tag, data and valid flag without a hit check. It issues a memory write (`mem_req` and `mem_we` high) carrying the full word to the word-aligned address. `cpu_stall` falls in the cycle after the write is acknowledged.
- R8: After a store, a load of the stored address hits and returns the stored word with no memory access. A line that held a different tag at that index is gone, so loading the old address misses.
- R9: The total stall for a miss or a store is 2 + L cycles, where L is the number of cycles `mem_ack` stays low while `mem_req` is high. During that wait, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` do not change until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store word |
| cpu_rdata | output | 32 | Load word, valid when the access completes |
| cpu_stall | output | 1 | Processor must hold its access while high |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Word written to memory |
| mem_ack | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | 32 | Word read from memory, valid with `mem_ack` |

## Verification
A load hit is due in the request cycle itself, so the bench samples `cpu_stall` and `cpu_rdata` one time unit after driving the request at the falling edge. A miss or a store with acknowledge delay L completes exactly 2 + L cycles later. The bench counts falling edges until the stall drops and compares that count with 2 + L, using the delay its memory model was set to. Memory traffic is counted on the acknowledge edges, so a hit is proven to cause no memory access, and the model's contents after a store show that the word was written through.

// File: rtl/dmc_pkg.sv
// Package: shared controller state encoding for the direct-mapped cache.
package dmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // lookup / accept a new access
        ST_FETCH,    // memory read outstanding for a load miss
        ST_FILLED,   // refill word returned to the processor
        ST_STORE,    // memory write outstanding for a store
        ST_STORED    // store released to the processor
    } ctrl_state_e;
endpackage

// File: rtl/dmc_line_store.sv
// Line storage: per-line valid flag, tag and data word.
// Assumes: one asynchronous read port addressed by the lookup index and
// one synchronous write port; only valid flags are reset (synchronously).
module dmc_line_store #(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Valid flags: cleared as a whole on reset, set by any line write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and data arrays: written together, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    // Combinational read of the indexed line.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_data  = data_q[rd_idx];
    end
endmodule

// File: rtl/dmc_tag_match.sv
// Hit detector: compares the stored tag with the request tag.
// Assumes: the stored tag and valid flag come from the line selected by the
// request index in the same cycle.
module dmc_tag_match #(
    parameter int TAG_W = 22
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);
    // A hit needs a valid line whose tag equals the request tag.
    always_comb begin
        hit = line_valid && (line_tag == req_tag);
    end
endmodule

// File: rtl/dmc_ctrl.sv
// Access controller: sequences load misses and write-through stores, drives
// the stall, the processor read data, the memory handshake and the line write.
// Assumes: the processor holds its access stable while cpu_stall is high; the
// memory holds mem_ack low until it completes the transfer.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    input  logic              hit,
    input  logic [DATA_W-1:0] line_data,
    output logic              fill_en,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [DATA_W-1:0] fill_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int WADDR_W = ADDR_W - 2;

    ctrl_state_e       state_q;
    logic [WADDR_W-1:0] word_addr_q;
    logic [DATA_W-1:0]  store_data_q;
    logic [DATA_W-1:0]  refill_q;
    logic               new_load_miss;
    logic               new_store;

    // Classify the access presented while idle.
    always_comb begin
        new_store     = (state_q == ST_IDLE) && cpu_req && cpu_we;
        new_load_miss = (state_q == ST_IDLE) && cpu_req && !cpu_we && !hit;
    end

    // State register and captured access fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            word_addr_q  <= '0;
            store_data_q <= '0;
            refill_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (new_store) begin
                        word_addr_q  <= cpu_addr[ADDR_W-1:2];
                        store_data_q <= cpu_wdata;
                        state_q      <= ST_STORE;
                    end else if (new_load_miss) begin
                        word_addr_q  <= cpu_addr[ADDR_W-1:2];
                        state_q      <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        refill_q <= mem_rdata;
                        state_q  <= ST_FILLED;
                    end
                end
                ST_STORE: begin
                    if (mem_ack) begin
                        state_q <= ST_STORED;
                    end
                end
                ST_FILLED: state_q <= ST_IDLE;
                ST_STORED: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Line write: a store writes at once, a refill writes on the read ack.
    always_comb begin
        if (state_q == ST_FETCH) begin
            fill_en   = mem_ack;
            fill_addr = {word_addr_q, 2'b00};
            fill_data = mem_rdata;
        end else begin
            fill_en   = new_store;
            fill_addr = cpu_addr;
            fill_data = cpu_wdata;
        end
    end

    // Processor side: stall on misses and stores, forward the refill word.
    always_comb begin
        cpu_stall = new_store || new_load_miss ||
                    (state_q == ST_FETCH) || (state_q == ST_STORE);
        cpu_rdata = (state_q == ST_FILLED) ? refill_q : line_data;
    end

    // Memory side: request held from the captured fields until acknowledged.
    always_comb begin
        mem_req   = (state_q == ST_FETCH) || (state_q == ST_STORE);
        mem_we    = (state_q == ST_STORE);
        mem_addr  = {word_addr_q, 2'b00};
        mem_wdata = store_data_q;
    end
endmodule

// File: rtl/dmc_cache.sv
// Top: direct-mapped write-through cache with one-word lines.
// Splits the address into byte offset, index and tag, connects the line
// store, the hit detector and the controller.
// Assumes: ADDR_W > IDX_W + 2; the byte offset is ignored (word accesses only).
module dmc_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int IDX_LO = 2;
    localparam int TAG_LO = IDX_LO + IDX_W;
    localparam int TAG_W  = ADDR_W - TAG_LO;

    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_data;
    logic              hit;
    logic              fill_en;
    logic [ADDR_W-1:0] fill_addr;
    logic [DATA_W-1:0] fill_data;

    // Lookup fields taken from the processor address.
    always_comb begin
        look_idx = cpu_addr[TAG_LO-1:IDX_LO];
        look_tag = cpu_addr[ADDR_W-1:TAG_LO];
    end

    dmc_line_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (look_idx),
        .rd_valid(line_valid),
        .rd_tag  (line_tag),
        .rd_data (line_data),
        .wr_en   (fill_en),
        .wr_idx  (fill_addr[TAG_LO-1:IDX_LO]),
        .wr_tag  (fill_addr[ADDR_W-1:TAG_LO]),
        .wr_data (fill_data)
    );

    dmc_tag_match #(
        .TAG_W(TAG_W)
    ) match_i (
        .line_valid(line_valid),
        .line_tag  (line_tag),
        .req_tag   (look_tag),
        .hit       (hit)
    );

    dmc_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall),
        .hit      (hit),
        .line_data(line_data),
        .fill_en  (fill_en),
        .fill_addr(fill_addr),
        .fill_data(fill_data),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata)
    );
endmodule

// File: rtl/dmc_cache_checker.sv
// Checker: port-level protocol properties of the cache, bound to dmc_cache.
module dmc_cache_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              cpu_stall,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_rdata
);
    // R3: the processor is held whenever a memory transfer is open.
    a_r3_stall_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall);

    // R3: memory addresses are word aligned.
    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R9: an unacknowledged request keeps all its fields.
    a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

    // R4: the acknowledged read word reaches the processor next cycle.
    a_r4_refill_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we) |=> (!cpu_stall && !mem_req &&
                                             cpu_rdata == $past(mem_rdata)));

    // R7: an acknowledged store releases the processor next cycle.
    a_r7_store_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_we) |=> (!cpu_stall && !mem_req));
endmodule

bind dmc_cache dmc_cache_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata)
);

// File: tb/dmc_cache_tb_top.sv
// Directed bench for dmc_cache: one task per scenario, each checking itself.
module dmc_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 8;
    localparam logic [31:0] STRIDE = 32'(1) << (IDX_W + 2);

    logic        clk;
    logic        rst_n;
    logic        cpu_req;
    logic        cpu_we;
    logic [31:0] cpu_addr;
    logic [31:0] cpu_wdata;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    int mem_lat  = 0;
    int wait_cnt = 0;
    int rd_count = 0;
    int wr_count = 0;
    logic [31:0] last_mem_addr = '0;
    bit   done = 0;
    logic [31:0] wmem [logic [29:0]];

    dmc_cache #(.ADDR_W(32), .DATA_W(32), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory contents: written words, otherwise a pattern of the word address.
    function automatic logic [31:0] mem_val(input logic [31:0] a);
        if (wmem.exists(a[31:2])) return wmem[a[31:2]];
        return {a[31:2], 2'b00} ^ 32'h5A5A_1234;
    endfunction

    // Memory model: acknowledges after mem_lat waiting cycles.
    always @(negedge clk) begin
        if (mem_req && !mem_ack && wait_cnt == mem_lat) begin
            mem_ack = 1'b1;
            last_mem_addr = mem_addr;
            if (mem_we) begin
                wmem[mem_addr[31:2]] = mem_wdata;
                wr_count++;
            end else begin
                mem_rdata = mem_val(mem_addr);
                rd_count++;
            end
            wait_cnt = 0;
        end else begin
            mem_ack = 1'b0;
            if (mem_req) wait_cnt++;
            else wait_cnt = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One processor access; returns the word and the number of stalled cycles.
    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        stalls = 0;
        #1;
        while (cpu_stall && stalls < 1000) begin
            @(negedge clk); #1;
            stalls++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Load and check data, stall length and memory read traffic.
    task automatic load_chk(input string req, input logic [31:0] addr, input bit miss,
                            input logic [31:0] exp);
        logic [31:0] rd; int st; int rc0;
        rc0 = rd_count;
        access(1'b0, addr, 32'h0, rd, st);
        chk(req, rd, exp);
        chk(req, 32'(st), miss ? 32'(2 + mem_lat) : 32'd0);
        chk(req, 32'(rd_count - rc0), miss ? 32'd1 : 32'd0);
    endtask

    task automatic t_reset_state();
        chk("R1 stall idle", {31'b0, cpu_stall}, 32'd0);
        chk("R1 no mem req", {31'b0, mem_req}, 32'd0);
        mem_lat = 0;
        load_chk("R1 first load misses", 32'h0000_1040, 1'b1, mem_val(32'h0000_1040));
    endtask

    task automatic t_miss_then_hit();
        logic [31:0] a = 32'h0003_2208;
        mem_lat = 3;
        load_chk("R3 miss", a, 1'b1, mem_val(a));
        chk("R3 aligned mem addr", last_mem_addr, a);
        load_chk("R4 refilled line hits", a, 1'b0, mem_val(a));
        load_chk("R2 hit again", a, 1'b0, mem_val(a));
    endtask

    task automatic t_byte_offset();
        logic [31:0] a = 32'h0003_2208;
        load_chk("R6 offset 3 hits", a + 32'd3, 1'b0, mem_val(a));
        load_chk("R6 offset 1 hits", a + 32'd1, 1'b0, mem_val(a));
    endtask

    task automatic t_conflict();
        logic [31:0] a = 32'h0003_2208;
        logic [31:0] b = a + STRIDE;
        mem_lat = 1;
        load_chk("R5 same index other tag misses", b, 1'b1, mem_val(b));
        load_chk("R5 evicted line misses", a, 1'b1, mem_val(a));
        load_chk("R5 next index still empty", a + 32'd4, 1'b1, mem_val(a + 32'd4));
    endtask

    task automatic t_store();
        logic [31:0] rd; int st; int wc0;
        logic [31:0] c = 32'h00A0_0310;
        mem_lat = 2;
        wc0 = wr_count;
        access(1'b1, c + 32'd2, 32'hCAFE_0001, rd, st);
        chk("R7 store stall", 32'(st), 32'(2 + mem_lat));
        chk("R7 one mem write", 32'(wr_count - wc0), 32'd1);
        chk("R7 word-aligned write addr", last_mem_addr, c);
        chk("R7 memory updated", mem_val(c), 32'hCAFE_0001);
        load_chk("R8 stored word hits", c, 1'b0, 32'hCAFE_0001);
    endtask

    task automatic t_store_evicts();
        logic [31:0] rd; int st;
        logic [31:0] a  = 32'h0000_5504;
        logic [31:0] a2 = a + 32'd5 * STRIDE;
        mem_lat = 0;
        load_chk("R8 fill old line", a, 1'b1, mem_val(a));
        access(1'b1, a2, 32'h1234_ABCD, rd, st);
        chk("R8 store stall", 32'(st), 32'd2);
        load_chk("R8 new tag hits", a2, 1'b0, 32'h1234_ABCD);
        load_chk("R8 old tag misses", a, 1'b1, mem_val(a));
        access(1'b1, a, 32'h0BAD_F00D, rd, st);
        load_chk("R7 store over valid line hits", a, 1'b0, 32'h0BAD_F00D);
        chk("R7 store over valid line memory", mem_val(a), 32'h0BAD_F00D);
    endtask

    task automatic t_latency_sweep();
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a = 32'h0700_0000 + 32'(i) * 32'h44;
            mem_lat = (i == 3) ? 9 : i * 2;
            load_chk("R9 miss latency", a, 1'b1, mem_val(a));
        end
    endtask

    task automatic t_reset_clears();
        logic [31:0] a = 32'h00A0_0310;
        do_reset();
        mem_lat = 1;
        load_chk("R1 cached line lost on reset", a, 1'b1, mem_val(a));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
        cpu_addr = '0; cpu_wdata = '0; mem_ack = 1'b0; mem_rdata = '0;
        do_reset();
        @(negedge clk); #1;
        t_reset_state();
        t_miss_then_hit();
        t_byte_offset();
        t_conflict();
        t_store();
        t_store_evicts();
        t_latency_sweep();
        t_reset_clears();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule